// File: doc/BRIEF.md
# Redundant Sensor Channel Voter

This block judges redundant readings of one physical quantity and decides whether a trustworthy value can be passed on. Each reading arrives as a signed sample on three channel inputs, qualified by a one-cycle strobe. A mode input selects how many channels take part, and a tolerance input sets how far two readings may differ and still count as the same value.

In dual mode only channels A and B take part. They are compared against the tolerance. A mismatch cannot be blamed on either channel, so the block raises a disagreement and latches a request for the safe state. In triplex mode the three channels are compared pairwise. When they all agree, the median is passed on. When exactly one pair agrees, the block outputs the mean of that pair, names the third channel as the outlier and marks it isolated for good. Every later triplex sample is then handled as a dual comparison of the two channels still in service. A second disagreement, or a triplex sample with no agreeing pair, latches the safe-state request.

All results are registered, and they appear one clock after the strobe that carried the sample.

Top module: `sensor_voter`

## Requirements
- R1: In dual mode (`tri_mode`=0), when |A−B| exceeds `tol`, the block sets `disagree`, keeps `vote_vld` low and latches `safe_req`. Channel C has no effect in dual mode. When the channels agree, `vote_out` is the mean of A and B.
- R2: A dual-mode result always reports `outlier` = 000.
- R3: `outlier` is one-hot or zero, with bit 0 = A, bit 1 = B and bit 2 = C. In triplex mode with no channel isolated, when exactly one pair agrees, `vote_out` is that pair's mean and `outlier` names the remaining channel.
- R4: In triplex mode with no channel isolated, when at least two pairs agree, `vote_out` is the median of the three channels, `outlier` = 000 and `disagree` = 0.
- R5: A channel reported as the outlier is set in `isolated` (same bit order as `outlier`). The bit stays set until reset, and at most one bit is ever set.
- R6: In triplex mode with one channel isolated, the block acts as the dual comparator on the two remaining channels. Agreement gives their mean with `outlier` = 000. Disagreement sets `disagree` and latches `safe_req`.
- R7: In triplex mode with no channel isolated, when no pair agrees, the block sets `disagree` and latches `safe_req`. Once `safe_req` is set it stays set until reset, `vote_vld` stays low, and further strobes change no output.
- R8: Two channels agree when their absolute difference is at most `tol`, the difference being formed one bit wider than the samples. Agreement therefore holds at exactly `tol` and fails at `tol`+1, even when the channels are at opposite ends of the signed range.
- R9: Outputs change only on the clock edge after a strobe. `vote_vld` is a one-cycle pulse. Without a strobe, `vote_out`, `outlier` and `disagree` hold their values.
- R10: A pair mean is rounded toward zero (for example, 3 and −6 give −1, and 32767 and −32768 give 0).
- R11: After reset, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_vld | input | 1 | Sample strobe; qualifies the channel inputs for one cycle |
| tri_mode | input | 1 | 1 = triplex voting, 0 = dual comparison of A and B |
| tol | input | DW | Unsigned agreement tolerance |
| ch_a | input | DW | Signed sample, channel A |
| ch_b | input | DW | Signed sample, channel B |
| ch_c | input | DW | Signed sample, channel C |
| vote_out | output | DW | Signed voted value |
| vote_vld | output | 1 | One-cycle pulse when `vote_out` carries a new agreed value |
| disagree | output | 1 | Last evaluated sample had no usable agreement |
| outlier | output | 3 | One-hot outlier of the last evaluated sample |
| isolated | output | 3 | Sticky isolation bits per channel |
| safe_req | output | 1 | Sticky safe-state request |

## Verification
The assertions check the following on every cycle: the outlier code is one-hot or zero; at most one channel is ever isolated, and an isolation bit never clears; the safe-state request is sticky and never coincides with a valid pulse; a valid pulse never appears without a preceding strobe; dual-mode results never name an outlier. Only the bench scenarios can show the numbers themselves, checked against values computed separately: the median and the rounded pair means, the inclusive tolerance edge at the ends of the signed range, the hand-over from triplex voting to the dual comparison after an isolation, and the safe state reached on a second fault.

// File: rtl/voter_pkg.sv
package voter_pkg;
  localparam int NCH = 3;
  localparam int NPAIR = 3;

  // pair order: 0 = A/B, 1 = A/C, 2 = B/C
  typedef enum logic [2:0] {
    SRC_MED  = 3'd0,
    SRC_AB   = 3'd1,
    SRC_AC   = 3'd2,
    SRC_BC   = 3'd3,
    SRC_NONE = 3'd4
  } vsrc_e;

  // channel left out when only the given pair is trusted
  function automatic logic [NCH-1:0] left_out(vsrc_e s);
    case (s)
      SRC_AB:  left_out = 3'b100;
      SRC_AC:  left_out = 3'b010;
      SRC_BC:  left_out = 3'b001;
      default: left_out = 3'b000;
    endcase
  endfunction

  function automatic vsrc_e pair_src(int p);
    case (p)
      0:       pair_src = SRC_AB;
      1:       pair_src = SRC_AC;
      default: pair_src = SRC_BC;
    endcase
  endfunction
endpackage

// File: rtl/vote_pair_cmp.sv
module vote_pair_cmp #(
  parameter int DW = 16
) (
  input  logic signed [DW-1:0] lhs,
  input  logic signed [DW-1:0] rhs,
  input  logic        [DW-1:0] tol,
  output logic                 agree,
  output logic signed [DW-1:0] avg
);
  localparam int WW = DW + 1;

  logic signed [WW-1:0] diff;
  logic        [WW-1:0] mag;
  logic signed [WW-1:0] sum;
  logic signed [WW-1:0] sum_adj;
  logic signed [WW-1:0] half;

  // widened difference cannot wrap
  always_comb begin
    diff = {lhs[DW-1], lhs} - {rhs[DW-1], rhs};
    mag  = diff[WW-1] ? WW'(-diff) : WW'(diff);
    agree = (mag <= {1'b0, tol});
  end

  // mean, rounded toward zero: bias odd negative sums up by one
  always_comb begin
    sum     = {lhs[DW-1], lhs} + {rhs[DW-1], rhs};
    sum_adj = sum + ((sum[WW-1] && sum[0]) ? WW'(1) : WW'(0));
    half    = sum_adj >>> 1;
    avg     = half[DW-1:0];
  end
endmodule

// File: rtl/vote_median3.sv
module vote_median3 #(
  parameter int DW = 16
) (
  input  logic signed [DW-1:0] a,
  input  logic signed [DW-1:0] b,
  input  logic signed [DW-1:0] c,
  output logic signed [DW-1:0] med
);
  logic signed [DW-1:0] lo_ab;
  logic signed [DW-1:0] hi_ab;
  logic signed [DW-1:0] hi_cap;

  always_comb begin
    lo_ab  = (a < b) ? a : b;
    hi_ab  = (a < b) ? b : a;
    hi_cap = (hi_ab < c) ? hi_ab : c;
    med    = (lo_ab > hi_cap) ? lo_ab : hi_cap;
  end
endmodule

// File: rtl/vote_decide.sv
module vote_decide
  import voter_pkg::*;
(
  input  logic             tri_mode,
  input  logic [NCH-1:0]   iso,
  input  logic [NPAIR-1:0] agree,
  output vsrc_e            src,
  output logic [NCH-1:0]   outl
);
  logic [1:0] n_agree;

  always_comb begin
    n_agree = 2'(agree[0]) + 2'(agree[1]) + 2'(agree[2]);
    src  = SRC_NONE;
    outl = '0;
    if (!tri_mode) begin
      src = agree[0] ? SRC_AB : SRC_NONE;
    end else begin
      case (iso)
        3'b000: begin
          if (n_agree >= 2'd2) begin
            src = SRC_MED;
          end else if (n_agree == 2'd1) begin
            for (int p = 0; p < NPAIR; p++) begin
              if (agree[p]) src = pair_src(p);
            end
            outl = left_out(src);
          end
        end
        3'b001:  src = agree[2] ? SRC_BC : SRC_NONE;
        3'b010:  src = agree[1] ? SRC_AC : SRC_NONE;
        3'b100:  src = agree[0] ? SRC_AB : SRC_NONE;
        default: src = SRC_NONE;
      endcase
    end
  end
endmodule

// File: rtl/sensor_voter.sv
module sensor_voter
  import voter_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 smp_vld,
  input  logic                 tri_mode,
  input  logic        [DW-1:0] tol,
  input  logic signed [DW-1:0] ch_a,
  input  logic signed [DW-1:0] ch_b,
  input  logic signed [DW-1:0] ch_c,
  output logic signed [DW-1:0] vote_out,
  output logic                 vote_vld,
  output logic                 disagree,
  output logic        [2:0]    outlier,
  output logic        [2:0]    isolated,
  output logic                 safe_req
);
  logic signed [DW-1:0] ch [NCH];
  logic [NPAIR-1:0]     agree;
  logic signed [DW-1:0] pavg [NPAIR];
  logic signed [DW-1:0] med;
  logic signed [DW-1:0] pick;
  vsrc_e                src;
  logic [NCH-1:0]       outl;

  assign ch[0] = ch_a;
  assign ch[1] = ch_b;
  assign ch[2] = ch_c;

  for (genvar p = 0; p < NPAIR; p++) begin : g_pair
    localparam int L = (p == 2) ? 1 : 0;
    localparam int R = (p == 0) ? 1 : 2;
    vote_pair_cmp #(.DW(DW)) u_cmp (
      .lhs  (ch[L]),
      .rhs  (ch[R]),
      .tol  (tol),
      .agree(agree[p]),
      .avg  (pavg[p])
    );
  end

  vote_median3 #(.DW(DW)) u_med (
    .a  (ch_a),
    .b  (ch_b),
    .c  (ch_c),
    .med(med)
  );

  vote_decide u_dec (
    .tri_mode(tri_mode),
    .iso     (isolated),
    .agree   (agree),
    .src     (src),
    .outl    (outl)
  );

  always_comb begin
    case (src)
      SRC_AB:  pick = pavg[0];
      SRC_AC:  pick = pavg[1];
      SRC_BC:  pick = pavg[2];
      default: pick = med;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vote_out <= '0;
      vote_vld <= 1'b0;
      disagree <= 1'b0;
      outlier  <= '0;
      isolated <= '0;
      safe_req <= 1'b0;
    end else begin
      vote_vld <= 1'b0;
      if (smp_vld && !safe_req) begin
        if (src == SRC_NONE) begin
          disagree <= 1'b1;
          outlier  <= '0;
          safe_req <= 1'b1;
        end else begin
          vote_out <= pick;
          vote_vld <= 1'b1;
          disagree <= 1'b0;
          outlier  <= outl;
          isolated <= isolated | outl;
        end
      end
    end
  end
endmodule

// File: rtl/sensor_voter_chk.sv
module sensor_voter_chk (
  input logic       clk,
  input logic       rst,
  input logic       smp_vld,
  input logic       tri_mode,
  input logic       vote_vld,
  input logic       disagree,
  input logic [2:0] outlier,
  input logic [2:0] isolated,
  input logic       safe_req
);
  logic up;
  always_ff @(posedge clk) up <= !rst;

  p_outlier_onehot_r3: assert property (@(posedge clk) disable iff (rst)
    $onehot0(outlier));
  p_single_iso_r5: assert property (@(posedge clk) disable iff (rst)
    $countones(isolated) <= 1);
  p_iso_sticky_r5: assert property (@(posedge clk) disable iff (rst)
    up |-> ((isolated & $past(isolated)) == $past(isolated)));
  p_safe_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    (up && $past(safe_req)) |-> safe_req);
  p_no_vld_in_safe_r7: assert property (@(posedge clk) disable iff (rst)
    safe_req |-> !vote_vld);
  p_vld_needs_strobe_r9: assert property (@(posedge clk) disable iff (rst)
    (up && !$past(smp_vld)) |-> !vote_vld);
  p_dual_no_outlier_r2: assert property (@(posedge clk) disable iff (rst)
    (up && $past(smp_vld && !tri_mode && !safe_req)) |-> (outlier == 3'b000));
  p_disagree_no_vld_r1: assert property (@(posedge clk) disable iff (rst)
    disagree |-> !vote_vld);
endmodule

bind sensor_voter sensor_voter_chk u_chk (
  .clk     (clk),
  .rst     (rst),
  .smp_vld (smp_vld),
  .tri_mode(tri_mode),
  .vote_vld(vote_vld),
  .disagree(disagree),
  .outlier (outlier),
  .isolated(isolated),
  .safe_req(safe_req)
);

// File: tb/sim_sensor_voter.sv
module sim_sensor_voter;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic smp_vld = 1'b0;
  logic tri_mode = 1'b0;
  logic [DW-1:0] tol = '0;
  logic signed [DW-1:0] ch_a = '0, ch_b = '0, ch_c = '0;
  logic signed [DW-1:0] vote_out;
  logic vote_vld, disagree, safe_req;
  logic [2:0] outlier, isolated;

  always #4 clk = ~clk;

  sensor_voter #(.DW(DW)) u0 (.*);

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  // reference state
  longint e_out;
  bit e_vld, e_dis, e_safe;
  bit [2:0] e_outl, e_iso;

  function automatic longint absl(longint x);
    return (x < 0) ? -x : x;
  endfunction
  function automatic longint mean2(longint x, longint y);
    return (x + y) / 2;  // integer division truncates toward zero
  endfunction
  function automatic longint med3(longint x, longint y, longint z);
    if ((x <= y && y <= z) || (z <= y && y <= x)) return y;
    if ((y <= x && x <= z) || (z <= x && x <= y)) return x;
    return z;
  endfunction

  task automatic model(input longint a, input longint b, input longint c,
                       input bit m, input longint t);
    bit ab, ac, bc;
    longint x, y;
    bit ok;
    e_vld = 0;
    if (e_safe) return;
    ab = absl(a - b) <= t;
    ac = absl(a - c) <= t;
    bc = absl(b - c) <= t;
    if (!m || e_iso != 0) begin
      if (!m || e_iso == 3'b100) begin x = a; y = b; ok = ab; end
      else if (e_iso == 3'b010) begin x = a; y = c; ok = ac; end
      else begin x = b; y = c; ok = bc; end
      e_outl = 0;
      if (ok) begin e_out = mean2(x, y); e_vld = 1; e_dis = 0; end
      else begin e_dis = 1; e_safe = 1; end
    end else begin
      int n;
      n = int'(ab) + int'(ac) + int'(bc);
      if (n >= 2) begin
        e_out = med3(a, b, c); e_vld = 1; e_dis = 0; e_outl = 0;
      end else if (n == 1) begin
        e_vld = 1; e_dis = 0;
        if (ab) begin e_out = mean2(a, b); e_outl = 3'b100; end
        else if (ac) begin e_out = mean2(a, c); e_outl = 3'b010; end
        else begin e_out = mean2(b, c); e_outl = 3'b001; end
        e_iso |= e_outl;
      end else begin
        e_dis = 1; e_outl = 0; e_safe = 1;
      end
    end
  endtask

  task automatic compare(input string req);
    n_run++;
    if (longint'(vote_out) != e_out || vote_vld != e_vld || disagree != e_dis ||
        outlier != e_outl || isolated != e_iso || safe_req != e_safe) begin
      n_fail++;
      $display("FAIL %s: got out=%0d vld=%0b dis=%0b outl=%b iso=%b safe=%0b exp out=%0d vld=%0b dis=%0b outl=%b iso=%b safe=%0b",
               req, vote_out, vote_vld, disagree, outlier, isolated, safe_req,
               e_out, e_vld, e_dis, e_outl, e_iso, e_safe);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1; smp_vld = 0;
    repeat (2) @(negedge clk);
    rst = 0;
    e_out = 0; e_vld = 0; e_dis = 0; e_safe = 0; e_outl = 0; e_iso = 0;
  endtask

  task automatic sample(input longint a, input longint b, input longint c,
                        input bit m, input longint t, input string req);
    @(negedge clk);
    ch_a = DW'(a); ch_b = DW'(b); ch_c = DW'(c); tri_mode = m; tol = DW'(t);
    smp_vld = 1;
    @(negedge clk);
    smp_vld = 0;
    model(a, b, c, m, t);
    compare(req);
  endtask

  task automatic idle(input string req);
    @(negedge clk);
    e_vld = 0;
    compare(req);
  endtask

  function automatic longint clip(longint v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_fail++;
      $display("FAIL watchdog: got hung run exp completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    do_reset();
    compare("R11 reset state");

    // R1 dual agree, C ignored in dual mode
    sample(100, 104, -9000, 0, 4, "R1 dual agree, C ignored");
    idle("R9 hold, one-cycle pulse");
    // R10 rounding toward zero
    sample(3, -6, 0, 0, 20, "R10 rounding negative");
    // R8 extremes, wide difference
    sample(32767, -32768, 0, 0, 65535, "R8 R10 extreme agree");
    sample(32767, -32768, 0, 0, 65534, "R8 R1 extreme disagree");
    sample(1, 1, 1, 0, 0, "R7 frozen in safe");
    do_reset();

    // R8 boundary at tol and tol+1
    sample(-50, -40, 0, 0, 10, "R8 diff equals tol");
    sample(-50, -39, 0, 0, 10, "R8 R1 R2 diff tol+1");
    do_reset();

    // R4 median
    sample(10, 12, 11, 1, 2, "R4 median all agree");
    sample(0, 2, 4, 1, 2, "R4 two pairs agree");
    // R3 R5 C outlier
    sample(20, 23, 900, 1, 5, "R3 R5 outlier C");
    // R6 now dual on A,B; C wild
    sample(40, 44, -30000, 1, 5, "R6 dual on remaining");
    sample(40, 60, 40, 1, 5, "R6 second fault to safe");
    do_reset();

    sample(500, -7, 503, 1, 5, "R3 R5 outlier B");
    sample(-3000, 9999, -2994, 1, 6, "R6 A,C remain");
    do_reset();
    sample(-800, 100, 104, 1, 5, "R3 outlier A");
    do_reset();
    sample(0, 100, 200, 1, 10, "R7 no pair agrees");
    idle("R7 hold in safe");
    do_reset();

    // constrained random
    for (int i = 0; i < 3000; i++) begin
      longint base, a, b, c, t;
      bit m;
      if (e_safe || $urandom_range(0, 199) == 0) do_reset();
      base = longint'($urandom_range(0, 64000)) - 32000;
      a = clip(base + longint'($urandom_range(0, 16)) - 8);
      b = clip(base + longint'($urandom_range(0, 16)) - 8);
      c = clip(base + longint'($urandom_range(0, 16)) - 8);
      case ($urandom_range(0, 11))
        0: a = clip(a + 5000);
        1: b = clip(b - 5000);
        2: c = clip(c + 5000);
        default: ;
      endcase
      t = longint'($urandom_range(0, 20));
      m = ($urandom_range(0, 3) != 0);
      sample(a, b, c, m, t, "R1 R3 R4 R6 random");
      if ($urandom_range(0, 7) == 0) idle("R9 random hold");
    end

    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule